// File: doc/BRIEF.md
# SPI Master Shifter

This block is a full-duplex serial-peripheral-interface master. Each frame goes out on one data line while a frame from the slave comes in on the other. Both are clocked by a serial clock that the block generates. An active-low select line frames the exchange.

The host programs the clock polarity, the clock phase, an 8- or 16-bit frame, MSB-first or LSB-first order, and a clock divisor. It passes words through a one-word transmit buffer and a one-word receive buffer. Each buffer has a flag, and each flag produces a one-cycle request strobe when it becomes set. An external data mover can use those strobes to keep frames running back to back.

Writing a word starts a transfer. If a second word is written while the first frame is shifting, the select line stays low and the next frame follows without a break. The configuration inputs are sampled only while the shifter is idle. During a transfer the block works from its captured copy.

Top module: `spi_master_core`

## Requirements
- R1: After reset, ss_n is 1, sclk is 0, tx_empty is 1, rx_full is 0, busy is 0, and tx_req and rx_req are 0.
- R2: Whenever ss_n is high, and at the moment ss_n is released, sclk rests at the level of cfg_cpol. Each frame makes exactly 2N sclk transitions, where N is the frame length. Even-numbered transitions (0, 2, ...) move sclk away from its rest level and are the leading edges.
- R3: With cfg_cpha=0, the first bit is on mosi before the first edge, both sides sample on leading edges, and data changes on trailing edges. With cfg_cpha=1, data changes on leading edges and is sampled on trailing edges.
- R4: With cfg_wide=0 a frame is 8 bits: tx_data[7:0] is sent and rx_data[15:8] reads 0. With cfg_wide=1 a frame is 16 bits.
- R5: With cfg_lsb_first=0, bit N-1 is sent first and the first bit received lands in bit N-1. With cfg_lsb_first=1, bit 0 is sent first and the first bit received lands in bit 0.
- R6: ss_n falls exactly cfg_div+1 clock cycles before the first sclk transition. Transitions within a frame are cfg_div+1 cycles apart.
- R7: A completed frame loads rx_data and sets rx_full. A one-cycle rx_rd pulse clears rx_full. rx_req pulses for one cycle each time rx_full goes from 0 to 1.
- R8: A tx_wr pulse stores tx_data and clears tx_empty for the next cycle. When the shifter takes the word, tx_empty returns to 1 and tx_req pulses for one cycle.
- R9: If a word is buffered when a frame's last edge has passed, ss_n stays low and the next frame begins 2(cfg_div+1) cycles after that last edge. Otherwise ss_n rises cfg_div+1 cycles after the last edge.
- R10: Changes to cfg_cpol, cfg_cpha, cfg_wide, cfg_lsb_first or cfg_div while busy is 1 do not affect the frames of the ongoing transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Rest level of sclk |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_wide | input | 1 | 0: 8-bit frame, 1: 16-bit frame |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_div | input | DIV_W | Half-period of sclk in clocks, minus one |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | W_LONG | Word to transmit |
| tx_empty | output | 1 | Transmit buffer can take a word |
| tx_req | output | 1 | One-cycle strobe when tx_empty becomes 1 |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | W_LONG | Last received word |
| rx_full | output | 1 | Receive buffer holds an unread word |
| rx_req | output | 1 | One-cycle strobe when rx_full becomes 1 |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Active-low slave select |

## Verification
The embedded properties rely on the divisor staying constant while the divider counts, on the shifter taking a word only while the transmit buffer is full, and on the slave changing miso only on its drive edge, never on the edge where the master samples. The bench's slave model follows that rule exactly, driving miso on the opposite edge from the one where it samples mosi. The bench sweeps all sixteen mode combinations at two divisors, with two back-to-back frames in every run. On alternate runs it scrambles every configuration input while the transfer is in progress, to confirm that the captured settings keep control of the frames.

// File: rtl/spim_pkg.sv
// Shared types for the SPI master shifter.
// Assumes nothing beyond being compiled before the modules that import it.
package spim_pkg;

    // Frame mode bits captured while the shifter is idle.
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic wide;
        logic lsb_first;
    } spim_mode_t;

    // Shifter sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } spim_state_e;

endpackage

// File: rtl/spim_clkgen.sv
// Half-period tick generator for the serial clock.
// Counts clocks while enabled and pulses tick every div+1 cycles.
// Assumes div stays constant while en is high.
module spim_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Half-period counter, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick marks the last cycle of each half-period.
    assign tick = en && (cnt == div);

    // The counter never runs past the divisor it was started with.
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= div));

endmodule

// File: rtl/spim_hostbuf.sv
// Host-side one-word transmit and receive buffers with empty/full flags.
// Each flag raises a one-cycle request strobe when it becomes set.
// A write overrides a same-cycle pop. A push overrides a same-cycle read.
module spim_hostbuf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         txe,
    output logic         tx_req,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rxne,
    output logic         rx_req
);

    logic [W-1:0] tx_hold;
    logic [W-1:0] rx_hold;
    logic         txe_d;
    logic         rxne_d;

    // Transmit holding register and its empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            txe     <= 1'b1;
        end else if (wr_en) begin
            tx_hold <= wr_data;
            txe     <= 1'b0;
        end else if (pop) begin
            txe     <= 1'b1;
        end
    end

    // Receive holding register and its full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rxne    <= 1'b0;
        end else if (push) begin
            rx_hold <= push_data;
            rxne    <= 1'b1;
        end else if (rd_en) begin
            rxne    <= 1'b0;
        end
    end

    // Delayed flags for rising-edge request strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txe_d  <= 1'b1;
            rxne_d <= 1'b0;
        end else begin
            txe_d  <= txe;
            rxne_d <= rxne;
        end
    end

    assign pop_data = tx_hold;
    assign rd_data  = rx_hold;
    assign tx_req   = txe & ~txe_d;
    assign rx_req   = rxne & ~rxne_d;

    // The shifter only takes a word that is actually buffered.
    p_pop_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !txe);

    // A host write leaves the buffer marked full.
    p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !txe);

    // A completed frame always leaves the receive flag set.
    p_push_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> rxne);

endmodule

// File: rtl/spim_shifter.sv
// Frame sequencer and shift registers of the SPI master.
// Captures the mode and divisor while idle, then runs 2N half-period
// edges per frame. It drives and samples according to phase and order,
// and chains frames while the transmit buffer stays full.
// Assumes tick comes from a divider enabled by busy and fed div_act.
module spim_shifter
    import spim_pkg::*;
#(
    parameter int W_LONG  = 16,
    parameter int W_SHORT = 8,
    parameter int DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spim_mode_t        mode_in,
    input  logic [DIV_W-1:0]  div_in,
    output logic [DIV_W-1:0]  div_act,
    input  logic              tick,
    input  logic              buf_full,
    input  logic [W_LONG-1:0] buf_data,
    output logic              pop,
    output logic              push,
    output logic [W_LONG-1:0] push_data,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);

    localparam int EC_W = $clog2(2 * W_LONG);
    localparam logic [EC_W-1:0] LAST_LONG  = EC_W'(2 * W_LONG - 1);
    localparam logic [EC_W-1:0] LAST_SHORT = EC_W'(2 * W_SHORT - 1);
    localparam logic [W_LONG-1:0] SHORT_MASK =
        {{(W_LONG - W_SHORT){1'b0}}, {W_SHORT{1'b1}}};

    spim_state_e       state;
    spim_mode_t        mode_q;
    spim_mode_t        cur_mode;
    logic [DIV_W-1:0]  div_q;
    logic [EC_W-1:0]   ec;
    logic [EC_W-1:0]   last_edge;
    logic [W_LONG-1:0] txsr;
    logic [W_LONG-1:0] rxsr;
    logic [W_LONG-1:0] rx_next;
    logic [W_LONG-1:0] loaded;
    logic              edge_ev;
    logic              leading;
    logic              is_last;
    logic              drive_ev;
    logic              sample_ev;
    logic              start_ev;

    // Place a word so the first bit to send sits at the shift-out end.
    function automatic logic [W_LONG-1:0] align_tx(input logic [W_LONG-1:0] d,
                                                   input spim_mode_t m);
        if (m.wide || m.lsb_first) begin
            return d;
        end
        return d << (W_LONG - W_SHORT);
    endfunction

    // Bit presented at the shift-out end.
    function automatic logic out_bit(input logic [W_LONG-1:0] sr,
                                     input spim_mode_t m);
        return m.lsb_first ? sr[0] : sr[W_LONG-1];
    endfunction

    // Shift register after one bit has left.
    function automatic logic [W_LONG-1:0] advance(input logic [W_LONG-1:0] sr,
                                                  input spim_mode_t m);
        return m.lsb_first ? (sr >> 1) : (sr << 1);
    endfunction

    // Mode in force: live inputs while idle, captured copy otherwise.
    assign cur_mode  = (state == ST_IDLE) ? mode_in : mode_q;
    assign div_act   = div_q;
    assign busy      = (state != ST_IDLE);

    // Edge bookkeeping for the current frame.
    assign last_edge = mode_q.wide ? LAST_LONG : LAST_SHORT;
    assign edge_ev   = (state == ST_SHIFT) && tick;
    assign leading   = ~ec[0];
    assign is_last   = (ec == last_edge);
    assign drive_ev  = edge_ev && (mode_q.cpha ? leading : (!leading && !is_last));
    assign sample_ev = edge_ev && (mode_q.cpha ? !leading : leading);
    assign start_ev  = buf_full &&
                       ((state == ST_IDLE) || ((state == ST_HOLD) && tick));
    assign pop       = start_ev;
    assign loaded    = align_tx(buf_data, cur_mode);

    // Capture the configuration only while no transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
        end else if (state == ST_IDLE) begin
            mode_q <= mode_in;
            div_q  <= div_in;
        end
    end

    // Sequencer for select, serial clock and edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sclk  <= 1'b0;
            ss_n  <= 1'b1;
            ec    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    sclk <= mode_in.cpol;
                    if (start_ev) begin
                        state <= ST_SHIFT;
                        ss_n  <= 1'b0;
                        ec    <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (is_last) begin
                            state <= ST_HOLD;
                        end else begin
                            ec <= ec + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        ec <= '0;
                        if (buf_full) begin
                            state <= ST_SHIFT;
                        end else begin
                            state <= ST_IDLE;
                            ss_n  <= 1'b1;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    ss_n  <= 1'b1;
                end
            endcase
        end
    end

    // Transmit shift register and registered data-out line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txsr <= '0;
            mosi <= 1'b0;
        end else if (start_ev) begin
            if (!cur_mode.cpha) begin
                mosi <= out_bit(loaded, cur_mode);
                txsr <= advance(loaded, cur_mode);
            end else begin
                txsr <= loaded;
            end
        end else if (drive_ev) begin
            mosi <= out_bit(txsr, mode_q);
            txsr <= advance(txsr, mode_q);
        end
    end

    // Next receive shift value, including a sample taken this cycle.
    always_comb begin
        rx_next = rxsr;
        if (sample_ev) begin
            rx_next = mode_q.lsb_first ? {miso, rxsr[W_LONG-1:1]}
                                       : {rxsr[W_LONG-2:0], miso};
        end
    end

    // Receive shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxsr <= '0;
        end else begin
            rxsr <= rx_next;
        end
    end

    // Received word, right-aligned for short frames.
    always_comb begin
        if (mode_q.wide) begin
            push_data = rx_next;
        end else if (mode_q.lsb_first) begin
            push_data = rx_next >> (W_LONG - W_SHORT);
        end else begin
            push_data = rx_next & SHORT_MASK;
        end
    end

    assign push = edge_ev && is_last;

    // After a whole frame of edges the clock is back at its rest level.
    p_sclk_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (sclk == mode_q.cpol));

    // Received words are only delivered inside a selected frame.
    p_push_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !ss_n);

    // The edge count stays within the captured frame length.
    p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (ec <= last_edge));

endmodule

// File: rtl/spi_master_core.sv
// Top level of the SPI master: host buffers, frame shifter and divider.
// Assumes one synchronous clock domain and a synchronous active-low reset.
module spi_master_core
    import spim_pkg::*;
#(
    parameter int W_LONG  = 16,
    parameter int W_SHORT = 8,
    parameter int DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_wide,
    input  logic              cfg_lsb_first,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_wr,
    input  logic [W_LONG-1:0] tx_data,
    output logic              tx_empty,
    output logic              tx_req,
    input  logic              rx_rd,
    output logic [W_LONG-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_req,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);

    spim_mode_t        mode_in;
    logic [DIV_W-1:0]  div_act;
    logic              tick;
    logic              pop;
    logic              push;
    logic [W_LONG-1:0] pop_data;
    logic [W_LONG-1:0] push_data;

    assign mode_in = '{cpol: cfg_cpol, cpha: cfg_cpha,
                       wide: cfg_wide, lsb_first: cfg_lsb_first};

    spim_hostbuf #(.W(W_LONG)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tx_wr),
        .wr_data   (tx_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .txe       (tx_empty),
        .tx_req    (tx_req),
        .push      (push),
        .push_data (push_data),
        .rd_en     (rx_rd),
        .rd_data   (rx_data),
        .rxne      (rx_full),
        .rx_req    (rx_req)
    );

    spim_clkgen #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .div   (div_act),
        .tick  (tick)
    );

    spim_shifter #(
        .W_LONG  (W_LONG),
        .W_SHORT (W_SHORT),
        .DIV_W   (DIV_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_in   (mode_in),
        .div_in    (cfg_div),
        .div_act   (div_act),
        .tick      (tick),
        .buf_full  (!tx_empty),
        .buf_data  (pop_data),
        .pop       (pop),
        .push      (push),
        .push_data (push_data),
        .busy      (busy),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .ss_n      (ss_n)
    );

endmodule

// File: tb/tb_spi_master_core.sv
module tb_spi_master_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_wide = 1'b0, cfg_lsb_first = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = 16'd0;
    logic        rx_rd = 1'b0;
    logic        miso = 1'b0;
    logic        tx_empty, tx_req, rx_full, rx_req, busy, sclk, mosi, ss_n;
    logic [15:0] rx_data;

    always #5 clk = ~clk;

    spi_master_core dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide),
        .cfg_lsb_first(cfg_lsb_first), .cfg_div(cfg_div),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty), .tx_req(tx_req),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_req(rx_req),
        .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected settings of the current run
    bit   e_cpol, e_cpha, e_wide, e_lsb;
    int   e_div, n_bits;
    logic [15:0] sw [2];
    logic [15:0] cap [2];
    // Slave model and line monitor state
    bit   mon_en = 1'b0;
    bit   first_after_ss;
    logic sclk_prev = 1'b0, ss_prev = 1'b1;
    int   gap, ei, bi, fidx, expgap;
    int   ss_rises, txreq_n, rxreq_n;
    bit   lead;

    function automatic logic sbit(input logic [15:0] w, input int b, input int n, input bit lsbf);
        return lsbf ? w[b] : w[n-1-b];
    endfunction

    function automatic void drive_slave();
        if (fidx < 2) miso = sbit(sw[fidx], bi, n_bits, e_lsb);
        else miso = 1'b0;
    endfunction

    function automatic void sample_slave();
        if (fidx < 2) cap[fidx][e_lsb ? bi : n_bits-1-bi] = mosi;
        bi++;
    endfunction

    // SPI slave model and edge timing monitor (R2, R3, R6, R9)
    always @(negedge clk) begin
        if (mon_en) begin
            gap++;
            if (ss_prev && !ss_n) begin
                gap = 0; first_after_ss = 1'b1; ei = 0; bi = 0; fidx = 0;
                if (!e_cpha) drive_slave();
            end else if (!ss_prev && ss_n) begin
                ss_rises++;
                check(gap == e_div + 1, "R9", "ss release delay", gap, e_div + 1);
                check(sclk == e_cpol, "R2", "sclk level at release", int'(sclk), int'(e_cpol));
                check(ei == 0 && bi == 0, "R2", "partial frame at release", ei, 0);
            end else if (!ss_n && (sclk !== sclk_prev)) begin
                expgap = (ei == 0 && !first_after_ss) ? 2 * (e_div + 1) : e_div + 1;
                check(gap == expgap, first_after_ss ? "R6" : ((ei == 0) ? "R9" : "R6"),
                      "edge spacing", gap, expgap);
                gap = 0;
                first_after_ss = 1'b0;
                lead = (sclk != e_cpol);
                check(lead == (ei % 2 == 0), "R2", "edge direction", int'(lead), int'(ei % 2 == 0));
                if (lead) begin
                    if (!e_cpha) sample_slave();
                    else drive_slave();
                end else begin
                    if (!e_cpha) begin
                        if (bi == n_bits) begin bi = 0; fidx++; end
                        drive_slave();
                    end else begin
                        sample_slave();
                        if (bi == n_bits) begin bi = 0; fidx++; end
                    end
                end
                ei++;
                if (ei == 2 * n_bits) ei = 0;
            end
            if (tx_req) txreq_n++;
            if (rx_req) rxreq_n++;
        end
        sclk_prev = sclk;
        ss_prev = ss_n;
    end

    task automatic get_rx(input int k, input logic [15:0] expw);
        int t;
        t = 0;
        while (!rx_full && t < 3000) begin @(negedge clk); t++; end
        check(rx_full == 1'b1, "R7", "rx_full never set", int'(rx_full), 1);
        check(rx_data == expw, (e_wide ? "R5" : "R4"), $sformatf("rx word %0d", k),
              int'(rx_data), int'(expw));
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        check(rx_full == 1'b0, "R7", "rx_full after read", int'(rx_full), 0);
    endtask

    task automatic set_cfg_inputs(input bit flip);
        cfg_cpol      = flip ? ~e_cpol : e_cpol;
        cfg_cpha      = flip ? ~e_cpha : e_cpha;
        cfg_wide      = flip ? ~e_wide : e_wide;
        cfg_lsb_first = flip ? ~e_lsb : e_lsb;
        cfg_div       = flip ? 8'd1 : 8'(e_div);
    endtask

    initial begin
        logic [15:0] tw [2];
        logic [15:0] mask;
        int t;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(ss_n == 1'b1, "R1", "ss_n in reset", int'(ss_n), 1);
        check(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
        check(tx_empty == 1'b1, "R1", "tx_empty in reset", int'(tx_empty), 1);
        check(rx_full == 1'b0, "R1", "rx_full in reset", int'(rx_full), 0);
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(tx_req == 1'b0 && rx_req == 1'b0, "R1", "req strobes in reset",
              int'({tx_req, rx_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        for (int run = 0; run < 32; run++) begin
            e_cpol = run[0]; e_cpha = run[1]; e_wide = run[2]; e_lsb = run[3];
            e_div  = (run >= 16) ? 2 : 0;
            n_bits = e_wide ? 16 : 8;
            mask   = e_wide ? 16'hFFFF : 16'h00FF;
            tw[0]  = 16'h3C5A ^ 16'(run * 16'h0B1D);
            tw[1]  = {tw[0][7:0], tw[0][15:8]} ^ 16'h8001;
            sw[0]  = ~tw[0] + 16'(run);
            sw[1]  = tw[0] ^ 16'hF0F0;
            cap[0] = 16'h0; cap[1] = 16'h0;
            ss_rises = 0; txreq_n = 0; rxreq_n = 0;
            set_cfg_inputs(1'b0);
            repeat (3) @(negedge clk);
            check(sclk == e_cpol, "R2", "sclk rest while idle", int'(sclk), int'(e_cpol));
            tx_data = tw[0]; tx_wr = 1'b1;
            @(negedge clk);
            tx_wr = 1'b0;
            check(tx_empty == 1'b0, "R8", "tx_empty after write", int'(tx_empty), 0);
            t = 0;
            while (!busy && t < 100) begin @(negedge clk); t++; end
            // R10: scramble configuration during odd runs
            if (run % 2 == 1) set_cfg_inputs(1'b1);
            repeat (2) @(negedge clk);
            tx_data = tw[1]; tx_wr = 1'b1;
            @(negedge clk);
            tx_wr = 1'b0;
            get_rx(0, sw[0] & mask);
            set_cfg_inputs(1'b0);
            get_rx(1, sw[1] & mask);
            t = 0;
            while (busy && t < 3000) begin @(negedge clk); t++; end
            repeat (2) @(negedge clk);
            check(cap[0] == (tw[0] & mask), "R5", "slave got word 0", int'(cap[0]), int'(tw[0] & mask));
            check(cap[1] == (tw[1] & mask), "R3", "slave got word 1", int'(cap[1]), int'(tw[1] & mask));
            check(ss_rises == 1, "R9", "select releases per transfer", ss_rises, 1);
            check(txreq_n == 2, "R8", "tx_req pulses", txreq_n, 2);
            check(rxreq_n == 2, "R7", "rx_req pulses", rxreq_n, 2);
            check(ss_n == 1'b1, "R10", "transfer ended", int'(ss_n), 1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule